// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (clock line plus bidirectional open-drain data line) that holds a 2048-byte memory built from registers. A bus master addresses it with a control byte whose top nibble is 1010. Through that byte the master can write bytes, set the internal address counter with a dummy write and then read after a repeated START, read at the counter without setting it first, or stream consecutive bytes for as long as it keeps acknowledging.

Both bus lines are brought into the system clock domain through a synchronizer. START and STOP are found as data-line edges while the clock line is high. Bit traffic is decoded on the synchronized clock edges. The data line is modelled as an input plus an active-high output enable that pulls the line low. A write-protect input blocks every change to the memory but leaves the bus protocol and reads untouched. The system clock must run well above the bus clock: about eight system cycles per bus half period is the minimum assumed.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset, and whenever no transfer is addressed to the slave, `sda_oe` is 0 (data line released).
- R2: A data-line fall while the clock line is high is a START and a data-line rise while the clock line is high is a STOP. A START, repeated or not, restarts control-byte reception at any point. A STOP returns the slave to idle at any point, including in the middle of a byte.
- R3: Bytes are received MSB first. The slave acknowledges a control byte (drives `sda_oe`=1 for the whole ninth clock) only when its bits 7:4 are 1010. Any other control byte gets no acknowledge, and the slave ignores the bus until the next START.
- R4: In a write (control byte bit 0 = 0), control bits 3:1 give address bits 10:8 and the next byte gives bits 7:0. Each following data byte is acknowledged, stored at the counter, and the counter steps by one.
- R5: While `wp_i` is 1, data bytes are still acknowledged and the counter still steps, but the memory keeps its contents.
- R6: A random read (a write of the word address, then a repeated START and a control byte with bit 0 = 1) returns the byte at that address.
- R7: A current-address read (START, then a control byte with bit 0 = 1) returns the byte at the counter. Control bits 3:1 are ignored in a read.
- R8: After a read byte, a master acknowledge (data line low on the ninth clock) makes the slave send the byte at the next address. A master no-acknowledge makes it release the line and wait for STOP or START.
- R9: The counter holds the address of the last accessed byte plus one and wraps from 0x7FF to 0x000, both for reads and for writes.
- R10: Read data leaves MSB first. `sda_oe` changes only after a synchronized clock-line fall or a START/STOP, never while the clock line is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the bus |
| wp_i | input | 1 | Write protect, 1 blocks all memory updates |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |

## Verification
A wrong state or bit count shows up at the ports as a misplaced acknowledge or a wrong data bit. In either case `sda_oe` differs from the expected value within the same bus clock phase, about three system cycles after the clock-line fall. The bench therefore compares `sda_oe` with its model on every system clock of every high phase. A wrong address counter or a wrong write gate does not show up until a later read returns a wrong byte. The sequence is therefore built so that every write, protected write, wrap and aborted transfer is followed by a current-address or random read of the affected locations.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

    localparam int          BYTE_W = 8;
    localparam logic [3:0]  DEV_ID = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CTRL,
        S_CACK,
        S_WADR,
        S_AACK,
        S_WDAT,
        S_DACK,
        S_RDAT,
        S_RACK
    } link_state_t;

    typedef struct packed {
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic logic ctrl_is_ours(input logic [BYTE_W-1:0] b);
        return b[BYTE_W-1 -: 4] == DEV_ID;
    endfunction

    function automatic logic slave_acks(input link_state_t s);
        return (s == S_CACK) || (s == S_AACK) || (s == S_DACK);
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync
    import twi_mem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q[0] <= 1'b1;
                    sda_q[0] <= 1'b1;
                end else begin
                    scl_q[0] <= scl_i;
                    sda_q[0] <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) begin
                    scl_q[g] <= 1'b1;
                    sda_q[g] <= 1'b1;
                end else begin
                    scl_q[g] <= scl_q[g-1];
                    sda_q[g] <= sda_q[g-1];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    logic scl_s;
    logic sda_s;
    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end

endmodule

// File: rtl/twi_byte_store.sv
module twi_byte_store
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [BYTE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[addr] <= wdata;
        end
    end

    assign rdata = cells[addr];

endmodule

// File: rtl/twi_link_fsm.sv
module twi_link_fsm
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  line_ev_t          ev,
    input  logic              wp_i,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              mem_we,
    output logic [BYTE_W-1:0] wr_data,
    output logic [ADDR_W-1:0] ptr,
    output logic              ptr_inc,
    output logic              ptr_load,
    output link_state_t       st
);
    localparam int BLK_W = ADDR_W - BYTE_W;
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] tx;
    logic              rd_dir;
    logic              mack;
    logic [BLK_W-1:0]  blk;

    logic quiet;
    logic byte_done;
    logic wr_step;
    logic rd_step;

    always_comb begin
        quiet     = !ev.start && !ev.stop;
        byte_done = ev.scl_fall && (cnt == LAST_BIT);
        ptr_load  = quiet && (st == S_WADR) && byte_done;
        wr_step   = quiet && (st == S_WDAT) && byte_done;
        rd_step   = quiet && ev.scl_fall &&
                    (((st == S_CACK) && rd_dir) || ((st == S_RACK) && mack));
        ptr_inc   = wr_step || rd_step;
        mem_we    = wr_step && !wp_i;
        wr_data   = rx;
    end

    always_comb begin
        if (slave_acks(st)) begin
            sda_oe = 1'b1;
        end else if (st == S_RDAT) begin
            sda_oe = !tx[BYTE_W-1];
        end else begin
            sda_oe = 1'b0;
        end
    end

    // address counter: loaded from the word address, stepped per byte
    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (ptr_load) begin
            ptr <= {blk, rx};
        end else if (ptr_inc) begin
            ptr <= ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= S_IDLE;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '1;
            rd_dir <= 1'b0;
            mack   <= 1'b0;
            blk    <= '0;
        end else if (ev.start) begin
            st  <= S_CTRL;
            cnt <= '0;
        end else if (ev.stop) begin
            st  <= S_IDLE;
            cnt <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    cnt <= '0;
                end
                S_CTRL, S_WADR, S_WDAT: begin
                    if (ev.scl_rise) begin
                        rx  <= {rx[BYTE_W-2:0], ev.sda};
                        cnt <= cnt + 1'b1;
                    end else if (byte_done) begin
                        cnt <= '0;
                        if (st == S_CTRL) begin
                            if (ctrl_is_ours(rx)) begin
                                st     <= S_CACK;
                                rd_dir <= rx[0];
                                if (!rx[0]) begin
                                    blk <= rx[BLK_W:1];
                                end
                            end else begin
                                st <= S_IDLE;
                            end
                        end else if (st == S_WADR) begin
                            st <= S_AACK;
                        end else begin
                            st <= S_DACK;
                        end
                    end
                end
                S_CACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        if (rd_dir) begin
                            st <= S_RDAT;
                            tx <= rd_data;
                        end else begin
                            st <= S_WADR;
                        end
                    end
                end
                S_AACK, S_DACK: begin
                    if (ev.scl_fall) begin
                        cnt <= '0;
                        st  <= S_WDAT;
                    end
                end
                S_RDAT: begin
                    if (ev.scl_rise) begin
                        cnt <= cnt + 1'b1;
                    end else if (ev.scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            cnt <= '0;
                            tx  <= '1;
                            st  <= S_RACK;
                        end else begin
                            tx <= {tx[BYTE_W-2:0], 1'b1};
                        end
                    end
                end
                S_RACK: begin
                    if (ev.scl_rise) begin
                        mack <= !ev.sda;
                    end else if (ev.scl_fall) begin
                        cnt <= '0;
                        if (mack) begin
                            st <= S_RDAT;
                            tx <= rd_data;
                        end else begin
                            st <= S_IDLE;
                        end
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_mem_pkg::*;
#(
    parameter int ADDR_W      = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_i,
    input  logic sda_i,
    input  logic wp_i,
    output logic sda_oe
);
    line_ev_t          ev;
    link_state_t       st;
    logic              mem_we;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] rd_data;
    logic [ADDR_W-1:0] ptr;
    logic              ptr_inc;
    logic              ptr_load;
    logic              link_idle;

    assign link_idle = (st == S_IDLE);

    twi_line_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    twi_link_fsm #(
        .ADDR_W (ADDR_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .wp_i     (wp_i),
        .rd_data  (rd_data),
        .sda_oe   (sda_oe),
        .mem_we   (mem_we),
        .wr_data  (wr_data),
        .ptr      (ptr),
        .ptr_inc  (ptr_inc),
        .ptr_load (ptr_load),
        .st       (st)
    );

    twi_byte_store #(
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk   (clk),
        .we    (mem_we),
        .addr  (ptr),
        .wdata (wr_data),
        .rdata (rd_data)
    );

endmodule

// File: rtl/twi_mem_checker.sv
module twi_mem_checker #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst,
    input logic              sda_oe,
    input logic              wp_i,
    input logic              mem_we,
    input logic [ADDR_W-1:0] ptr,
    input logic              ptr_inc,
    input logic              ptr_load,
    input logic              scl_fall,
    input logic              line_start,
    input logic              line_stop,
    input logic              link_idle
);
    localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        link_idle |-> !sda_oe);

    assert_write_at_fall_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (scl_fall && !line_start && !line_stop));

    assert_protect_R5: assert property (@(posedge clk) disable iff (rst)
        wp_i |-> !mem_we);

    assert_ptr_step_R9: assert property (@(posedge clk) disable iff (rst)
        (ptr_inc && !ptr_load) |=> (ptr == $past(ptr) + ONE));

    assert_oe_after_fall_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe) |-> ($past(scl_fall) || $past(line_start) || $past(line_stop)));

endmodule

bind twi_mem_slave twi_mem_checker #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sda_oe     (sda_oe),
    .wp_i       (wp_i),
    .mem_we     (mem_we),
    .ptr        (ptr),
    .ptr_inc    (ptr_inc),
    .ptr_load   (ptr_load),
    .scl_fall   (ev.scl_fall),
    .line_start (ev.start),
    .line_stop  (ev.stop),
    .link_idle  (link_idle)
);

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
    localparam int Q     = 8;
    localparam int DEPTH = 2048;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst;
    logic scl;
    logic m_sda;
    logic wp;
    logic sda_oe;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_oe;

    twi_mem_slave i_twi_mem_slave (
        .clk    (clk),
        .rst    (rst),
        .scl_i  (scl),
        .sda_i  (sda_bus),
        .wp_i   (wp),
        .sda_oe (sda_oe)
    );

    logic [7:0] mem_m [DEPTH];
    int         ctr_m;
    logic       exp_oe;
    logic       cmp_en;
    string      cur_req;
    int         n_cmp;
    int         n_bad;
    bit         done;
    int         cyc;

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // per-clock comparison of the line driver against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            n_cmp++;
            if (sda_oe !== exp_oe) begin
                n_bad++;
                $display("FAIL %s: sda_oe=%0b expected %0b at %0t", cur_req, sda_oe, exp_oe, $time);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: cycles=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check_byte(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: read byte=%02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus_bit(input logic b, input logic eo, output logic seen);
        m_sda = b;
        tick(Q);
        scl    = 1'b1;
        exp_oe = eo;
        tick(3);
        cmp_en = 1'b1;
        tick(Q);
        seen = sda_bus;
        tick(Q - 6);
        cmp_en = 1'b0;
        tick(3);
        scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_sda = 1'b0;
        tick(Q);
        scl = 1'b0;
        tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0;
        tick(Q);
        scl = 1'b1;
        tick(Q);
        m_sda = 1'b1;
        tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] d, input logic ack_exp, input string req);
        logic s;
        cur_req = req;
        for (int i = 7; i >= 0; i--) bus_bit(d[i], 1'b0, s);
        bus_bit(1'b1, ack_exp, s);
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic give_ack, input string req);
        logic       s;
        logic [7:0] got;
        cur_req = req;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, ~exp[i], s);
            got[i] = s;
        end
        check_byte(req, got, exp);
        bus_bit(!give_ack, 1'b0, s);
    endtask

    function automatic logic [7:0] ctrl_of(input logic [10:0] a, input logic rd);
        return {4'b1010, a[10:8], rd};
    endfunction

    // R4 / R5: write n bytes (packed MSB-first in d) starting at addr
    task automatic do_write(input logic [10:0] addr, input int n, input logic [31:0] d, input string req);
        bus_start();
        send_byte(ctrl_of(addr, 1'b0), 1'b1, req);
        send_byte(addr[7:0], 1'b1, req);
        ctr_m = int'(addr);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b;
            b = d[31 - 8*i -: 8];
            send_byte(b, 1'b1, req);
            if (!wp) mem_m[ctr_m] = b;
            ctr_m = (ctr_m + 1) % DEPTH;
        end
        bus_stop();
    endtask

    // R6 / R8: dummy write of address, repeated START, n reads
    task automatic do_rand_read(input logic [10:0] addr, input int n, input string req);
        bus_start();
        send_byte(ctrl_of(addr, 1'b0), 1'b1, req);
        send_byte(addr[7:0], 1'b1, req);
        ctr_m = int'(addr);
        bus_start();
        send_byte(ctrl_of(addr, 1'b1), 1'b1, req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = mem_m[ctr_m];
            ctr_m = (ctr_m + 1) % DEPTH;
            recv_byte(e, i < n - 1, req);
        end
        bus_stop();
    endtask

    // R7: read at the counter, block bits in the control byte are ignored
    task automatic do_cur_read(input logic [2:0] blkbits, input int n, input string req);
        bus_start();
        send_byte({4'b1010, blkbits, 1'b1}, 1'b1, req);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = mem_m[ctr_m];
            ctr_m = (ctr_m + 1) % DEPTH;
            recv_byte(e, i < n - 1, req);
        end
        bus_stop();
    endtask

    initial begin
        logic s;
        n_cmp  = 0;
        n_bad  = 0;
        done   = 1'b0;
        cyc    = 0;
        cmp_en = 1'b0;
        exp_oe = 1'b0;
        scl    = 1'b1;
        m_sda  = 1'b1;
        wp     = 1'b0;
        rst    = 1'b1;
        ctr_m  = 0;
        cur_req = "R1";
        tick(6);
        rst = 1'b0;

        // R1: released after reset while the bus is idle
        cur_req = "R1 reset";
        exp_oe  = 1'b0;
        cmp_en  = 1'b1;
        tick(20);
        cmp_en  = 1'b0;

        // R4: two-byte write at 0x123, then two more bytes at 0x125
        do_write(11'h123, 2, 32'h5AC3_0000, "R4 write");
        do_write(11'h125, 2, 32'h7E9D_0000, "R4 write");

        // R6 and R8 and R10: random read with a sequential byte
        do_rand_read(11'h123, 2, "R6 random read");
        do_rand_read(11'h124, 1, "R6 random read");

        // R7: current read with unrelated block bits in the control byte
        do_cur_read(3'b111, 1, "R7 current read");

        // R9: write across the top of the array, then read across it
        do_write(11'h7FE, 4, 32'h1122_3344, "R9 wrap write");
        do_rand_read(11'h7FF, 2, "R9 wrap read");
        do_cur_read(3'b010, 1, "R9 counter after wrap");

        // R5: protected write acknowledged, memory unchanged, counter moves
        wp = 1'b1;
        do_write(11'h123, 2, 32'hFF00_0000, "R5 protected write");
        wp = 1'b0;
        do_cur_read(3'b000, 1, "R5 counter after protected write");
        do_rand_read(11'h123, 2, "R5 contents kept");

        // R3: foreign control bytes are not acknowledged and later bytes are ignored
        bus_start();
        send_byte(8'h90, 1'b0, "R3 foreign id");
        send_byte(8'h00, 1'b0, "R3 ignored byte");
        bus_stop();
        bus_start();
        send_byte(8'hB3, 1'b0, "R3 foreign id");
        bus_stop();
        do_cur_read(3'b001, 1, "R3 counter untouched");

        // R2: STOP in the middle of a control byte aborts it
        bus_start();
        cur_req = "R2 partial byte";
        bus_bit(1'b1, 1'b0, s);
        bus_bit(1'b0, 1'b0, s);
        bus_bit(1'b1, 1'b0, s);
        bus_bit(1'b0, 1'b0, s);
        bus_stop();
        cur_req = "R2 idle after stop";
        exp_oe  = 1'b0;
        cmp_en  = 1'b1;
        tick(10);
        cmp_en  = 1'b0;
        do_cur_read(3'b100, 1, "R2 read after abort");

        // R8: longer sequential stream
        do_rand_read(11'h123, 4, "R8 sequential");

        tick(10);
        finish_run();
    end

endmodule